// File: doc/BRIEF.md
# Key-Protected Independent Watchdog

The block is a watchdog down-counter that runs from its own slow clock. Software controls it through a small word-addressed register port. A key register takes magic codes. One code starts the counter, one feeds it, one opens the configuration registers for writing, and one closes them again. A power-of-two prescaler divides the clock ahead of a 12-bit down-counter. When the counter runs out, the block raises a one-cycle reset request and starts a new period from the reload value.

Prescaler and reload writes are posted. Each write lands in a pending register and takes effect a fixed number of clock cycles later. While a write is in flight, a busy bit in the status register is set. An optional early-warning interrupt rises when the counter steps onto a programmed compare value. It stays high until software writes the acknowledge bit.

Top module: `key_wdog`

## Requirements
- R1: Byte offsets are key 0x00, prescaler 0x04, reload 0x08, status 0x0C, window 0x10 and early control 0x14. After reset, the prescaler reads 0, the reload reads 0xFFF, the status reads 0, the early control reads 0, and both outputs are low.
- R2: Key 0x5555 opens the prescaler, reload and early-control fields for writing, and key 0x0000 closes them. Writes to these fields while they are closed leave their read values unchanged.
- R3: A key value that is not one of 0x5555, 0x0000, 0xCCCC or 0xAAAA closes the protected fields and does nothing else.
- R4: A prescaler or reload write sets status bit 0 or bit 1 respectively. The bit stays set for exactly 3 cycles, and the new value drives the counter from the cycle in which the bit clears. Reads return the last accepted write at once.
- R5: Key 0xCCCC loads the counter and starts counting. rst_req_o pulses for one cycle every (reload+1)·(4<<prescaler) cycles, measured from the loading edge.
- R6: Key 0xAAAA reloads the counter from the active reload value and restarts the prescaler, so the next pulse comes a full period after the feed.
- R7: A prescaler field above the largest supported code divides by the largest supported ratio.
- R8: The early control holds a compare value in bits 11:0 and an enable in bit 15. While the enable is set, early_irq_o rises in the cycle after a count step leaves the counter equal to the compare value.
- R9: Writing early control with bit 14 set clears early_irq_o whether the fields are open or closed. A write while closed changes neither the compare value nor the enable.
- R10: Before 0xCCCC no reset request is raised. Once started, no key or register write stops the counter.
- R11: The window register always reads 0xFFF and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Low-speed counter clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Register byte offset |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data for reg_addr_i (combinational) |
| rst_req_o | output | 1 | One-cycle reset request on expiry |
| early_irq_o | output | 1 | Early-warning interrupt, held until acknowledged |

## Verification
The bench builds the block with the largest prescaler code set to 8, which gives ratios up to 1024, and leaves the update latency at 3. With a 4-bit prescaler field, this setting lets the clamp be reached by writing code 15. The bench uses small reload values so that periods of 16 to 2048 cycles can be measured exactly. Between phases it parks the counter at reload 0xFFF, so no stray reset request falls inside a later phase.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
  localparam logic [15:0] KEY_GO   = 16'hCCCC;
  localparam logic [15:0] KEY_FEED = 16'hAAAA;
  localparam logic [15:0] KEY_OPEN = 16'h5555;
  localparam logic [15:0] KEY_SHUT = 16'h0000;

  localparam logic [4:0] A_KEY  = 5'h00;
  localparam logic [4:0] A_PRE  = 5'h04;
  localparam logic [4:0] A_RLD  = 5'h08;
  localparam logic [4:0] A_STAT = 5'h0C;
  localparam logic [4:0] A_WIN  = 5'h10;
  localparam logic [4:0] A_EWI  = 5'h14;

  localparam int EWI_ACK_BIT = 14;
  localparam int EWI_EN_BIT  = 15;
endpackage

// File: rtl/kwd_keys.sv
module kwd_keys
  import kwd_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        key_we_i,
  input  logic [15:0] key_i,
  output logic        unlocked_o,
  output logic        start_o,
  output logic        feed_o,
  output logic        running_o
);
  logic unlocked_q, running_q;

  assign start_o    = key_we_i && (key_i == KEY_GO);
  assign feed_o     = key_we_i && (key_i == KEY_FEED);
  assign unlocked_o = unlocked_q;
  assign running_o  = running_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      unlocked_q <= 1'b0;
      running_q  <= 1'b0;
    end else if (key_we_i) begin
      case (key_i)
        KEY_OPEN: unlocked_q <= 1'b1;
        KEY_SHUT: unlocked_q <= 1'b0;
        KEY_GO:   running_q  <= 1'b1;
        KEY_FEED: ;
        default:  unlocked_q <= 1'b0;
      endcase
    end
  end

  // R10
  run_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    running_q |=> running_q);

  // R3
  bad_key_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_we_i && key_i != KEY_OPEN && key_i != KEY_SHUT && key_i != KEY_GO &&
     key_i != KEY_FEED) |=> !unlocked_q);
endmodule

// File: rtl/kwd_posted.sv
module kwd_posted #(
  parameter int          W       = 12,
  parameter int          LAT     = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] pend_o,
  output logic [W-1:0] act_o,
  output logic         busy_o
);
  localparam int CW = $clog2(LAT + 1);

  logic [W-1:0]  pend_q, act_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= RST_VAL;
      act_q  <= RST_VAL;
      cnt_q  <= '0;
    end else if (we_i) begin
      pend_q <= d_i;
      cnt_q  <= CW'(LAT);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CW'(1);
      if (cnt_q == CW'(1)) act_q <= pend_q;
    end
  end

  assign pend_o = pend_q;
  assign act_o  = act_q;
  assign busy_o = (cnt_q != '0);

  // R4
  post_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> busy_o);

  // R4
  post_idle_act_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !we_i) |=> $stable(act_q));

  // R2
  post_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(pend_q));
endmodule

// File: rtl/kwd_core.sv
module kwd_core #(
  parameter int RLD_W    = 12,
  parameter int PRE_W    = 4,
  parameter int MAX_CODE = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             running_i,
  input  logic             load_i,
  input  logic [PRE_W-1:0] pre_code_i,
  input  logic [RLD_W-1:0] rld_i,
  input  logic [RLD_W-1:0] cmp_i,
  input  logic             irq_en_i,
  input  logic             ack_i,
  output logic             rst_req_o,
  output logic             irq_o
);
  localparam int DIV_W = MAX_CODE + 2;

  logic [PRE_W-1:0] code_eff;
  logic [DIV_W-1:0] div_last, pcnt_q;
  logic [RLD_W-1:0] cnt_q;
  logic             tick, rst_req_q, irq_q, hit;

  // clamp to the largest ratio, then last = 2^(code+2)-1
  assign code_eff = (pre_code_i > PRE_W'(MAX_CODE)) ? PRE_W'(MAX_CODE) : pre_code_i;
  assign div_last = {DIV_W{1'b1}} >> (PRE_W'(MAX_CODE) - code_eff);
  assign tick     = running_i && !load_i && (pcnt_q >= div_last);
  assign hit      = tick && (cnt_q != '0) && ((cnt_q - RLD_W'(1)) == cmp_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pcnt_q <= '0;
      cnt_q  <= '1;
    end else if (load_i) begin
      pcnt_q <= '0;
      cnt_q  <= rld_i;
    end else if (running_i) begin
      if (tick) begin
        pcnt_q <= '0;
        cnt_q  <= (cnt_q == '0) ? rld_i : cnt_q - RLD_W'(1);
      end else begin
        pcnt_q <= pcnt_q + DIV_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_req_q <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      rst_req_q <= tick && (cnt_q == '0);
      if (irq_en_i && hit) irq_q <= 1'b1;
      else if (ack_i)      irq_q <= 1'b0;
    end
  end

  assign rst_req_o = rst_req_q;
  assign irq_o     = irq_q;

  // R5
  req_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_q |=> !rst_req_q);

  // R10
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !running_i |-> !rst_req_q);

  // R9
  irq_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_q && !ack_i) |=> irq_q);

  // R8
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_q && !irq_en_i) |=> !irq_q);
endmodule

// File: rtl/key_wdog.sv
module key_wdog
  import kwd_pkg::*;
#(
  parameter int RLD_W        = 12,
  parameter int PRE_W        = 4,
  parameter int MAX_PRE_CODE = 6,
  parameter int UPD_LAT      = 3
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [4:0]  reg_addr_i,
  input  logic [15:0] reg_wdata_i,
  output logic [15:0] reg_rdata_o,
  output logic        rst_req_o,
  output logic        early_irq_o
);
  localparam logic [RLD_W-1:0] RLD_MAX = '1;

  logic             unlocked, start, feed, running;
  logic             pre_we, rld_we, ewi_we, ewi_ack;
  logic [PRE_W-1:0] pre_pend, pre_act;
  logic [RLD_W-1:0] rld_pend, rld_act, ewi_cmp_q;
  logic             pre_busy, rld_busy, ewi_en_q;

  assign pre_we  = reg_we_i && unlocked && (reg_addr_i == A_PRE);
  assign rld_we  = reg_we_i && unlocked && (reg_addr_i == A_RLD);
  assign ewi_we  = reg_we_i && unlocked && (reg_addr_i == A_EWI);
  assign ewi_ack = reg_we_i && (reg_addr_i == A_EWI) && reg_wdata_i[EWI_ACK_BIT];

  kwd_keys u_keys (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .key_we_i  (reg_we_i && (reg_addr_i == A_KEY)),
    .key_i     (reg_wdata_i),
    .unlocked_o(unlocked),
    .start_o   (start),
    .feed_o    (feed),
    .running_o (running)
  );

  kwd_posted #(.W(PRE_W), .LAT(UPD_LAT), .RST_VAL('0)) u_pre (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_i  (pre_we),
    .d_i   (reg_wdata_i[PRE_W-1:0]),
    .pend_o(pre_pend),
    .act_o (pre_act),
    .busy_o(pre_busy)
  );

  kwd_posted #(.W(RLD_W), .LAT(UPD_LAT), .RST_VAL(RLD_MAX)) u_rld (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_i  (rld_we),
    .d_i   (reg_wdata_i[RLD_W-1:0]),
    .pend_o(rld_pend),
    .act_o (rld_act),
    .busy_o(rld_busy)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ewi_cmp_q <= '0;
      ewi_en_q  <= 1'b0;
    end else if (ewi_we) begin
      ewi_cmp_q <= reg_wdata_i[RLD_W-1:0];
      ewi_en_q  <= reg_wdata_i[EWI_EN_BIT];
    end
  end

  kwd_core #(.RLD_W(RLD_W), .PRE_W(PRE_W), .MAX_CODE(MAX_PRE_CODE)) u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .running_i (running),
    .load_i    (start || feed),
    .pre_code_i(pre_act),
    .rld_i     (rld_act),
    .cmp_i     (ewi_cmp_q),
    .irq_en_i  (ewi_en_q),
    .ack_i     (ewi_ack),
    .rst_req_o (rst_req_o),
    .irq_o     (early_irq_o)
  );

  always_comb begin
    case (reg_addr_i)
      A_PRE:   reg_rdata_o = 16'(pre_pend);
      A_RLD:   reg_rdata_o = 16'(rld_pend);
      A_STAT:  reg_rdata_o = {14'b0, rld_busy, pre_busy};
      A_WIN:   reg_rdata_o = 16'(RLD_MAX);
      A_EWI:   reg_rdata_o = {ewi_en_q, 15'(ewi_cmp_q)};
      default: reg_rdata_o = 16'h0000;
    endcase
  end

  // R2
  ewi_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == A_EWI && !unlocked) |=> ($stable(ewi_cmp_q) && $stable(ewi_en_q)));

  // R9
  ack_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ewi_ack && !(ewi_en_q && early_irq_o)) |=> !early_irq_o);
endmodule

// File: tb/key_wdog_test.sv
`timescale 1ns/1ps
module key_wdog_test;
  localparam int MAXC = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [4:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        rst_req, irq;

  int nvec = 0;
  int nfail = 0;
  int cyc = 0;
  int exp_q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  key_wdog #(.MAX_PRE_CODE(MAXC)) uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .rst_req_o(rst_req),
    .early_irq_o(irq)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d, output int at);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
    at = cyc;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic wait_until(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  // expiry monitor: pops the expected cycle of each reset request
  always @(negedge clk) begin
    if (rst_n && rst_req) begin
      nvec++;
      if (exp_q.size() == 0) begin
        nfail++;
        $display("FAIL R5: unexpected reset request at %0d expected none", cyc);
      end else begin
        int e;
        e = exp_q.pop_front();
        if (e != cyc) begin
          nfail++;
          $display("FAIL R5/R6: reset request at %0d expected %0d", cyc, e);
        end
      end
    end
  end

  task automatic park();
    int w, t;
    wr(5'h08, 16'h0FFF, w);
    wait_until(w + 3);
    wr(5'h00, 16'hAAAA, t);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    logic [15:0] d;
    int w, s, r, r2, a;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values
    rd(5'h04, d); chk("R1 pre", d, 16'h0000);
    rd(5'h08, d); chk("R1 rld", d, 16'h0FFF);
    rd(5'h0C, d); chk("R1 stat", d, 16'h0000);
    rd(5'h14, d); chk("R1 ewi", d, 16'h0000);
    chk("R1 outputs", {14'b0, rst_req, irq}, 16'h0000);

    // R2 locked write ignored
    wr(5'h04, 16'h0001, w);
    rd(5'h04, d); chk("R2 locked pre", d, 16'h0000);
    rd(5'h0C, d); chk("R2 locked stat", d, 16'h0000);

    // R4 posted reload update
    wr(5'h00, 16'h5555, w);
    wr(5'h08, 16'h0003, w);
    rd(5'h0C, d); chk("R4 busy set", d, 16'h0002);
    rd(5'h08, d); chk("R4 read pend", d, 16'h0003);
    wait_until(w + 2);
    rd(5'h0C, d); chk("R4 busy 3rd cycle", d, 16'h0002);
    wait_until(w + 3);
    rd(5'h0C, d); chk("R4 busy clear", d, 16'h0000);

    // R10 idle: no request before start
    wait_until(w + 40);

    // R5 start, two periods of 16
    wr(5'h00, 16'hCCCC, s);
    exp_q.push_back(s + 16);
    exp_q.push_back(s + 32);
    wait_until(s + 33);
    park();

    // R6 feeding restarts a full period; prescaler code 1 = ratio 8
    wr(5'h04, 16'h0001, w);
    rd(5'h0C, d); chk("R4 pre busy", d, 16'h0001);
    wr(5'h08, 16'h0007, w);
    wait_until(w + 3);
    wr(5'h00, 16'hAAAA, r);
    exp_q.push_back(r + 64);
    wait_until(r + 74);
    wr(5'h00, 16'hAAAA, r2);
    exp_q.push_back(r2 + 64);
    wait_until(r2 + 65);
    park();

    // R7 clamp: code 15 acts as code 8 (ratio 1024)
    wr(5'h04, 16'h000F, w);
    wr(5'h08, 16'h0001, w);
    wait_until(w + 3);
    wr(5'h00, 16'hAAAA, r);
    exp_q.push_back(r + 2048);
    rd(5'h04, d); chk("R7 pre read", d, 16'h000F);
    wait_until(r + 2049);
    wr(5'h04, 16'h0000, w);
    park();

    // R8 early interrupt at compare 2, reload 5, ratio 4
    wr(5'h14, 16'h8002, w);
    wr(5'h08, 16'h0005, w);
    wait_until(w + 3);
    wr(5'h00, 16'hAAAA, r);
    exp_q.push_back(r + 24);
    wait_until(r + 11);
    chk("R8 irq before", {15'b0, irq}, 16'h0000);
    wait_until(r + 12);
    chk("R8 irq rise", {15'b0, irq}, 16'h0001);
    wait_until(r + 13);
    // R9 ack while locked
    wr(5'h00, 16'h0000, w);
    chk("R9 irq held", {15'b0, irq}, 16'h0001);
    wr(5'h14, 16'h4000, a);
    chk("R9 ack clears", {15'b0, irq}, 16'h0000);
    rd(5'h14, d); chk("R9 cfg kept", d, 16'h8002);
    wait_until(r + 35);
    chk("R8 irq low", {15'b0, irq}, 16'h0000);
    wait_until(r + 36);
    chk("R8 irq again", {15'b0, irq}, 16'h0001);
    wr(5'h00, 16'h5555, w);
    wr(5'h14, 16'hC002, a);
    chk("R9 ack open", {15'b0, irq}, 16'h0000);
    park();

    // R3 bad key locks
    wr(5'h00, 16'h1234, w);
    wr(5'h08, 16'h0009, w);
    rd(5'h08, d); chk("R3 rld unchanged", d, 16'h0FFF);
    rd(5'h0C, d); chk("R3 stat", d, 16'h0000);
    wr(5'h04, 16'h0002, w);
    rd(5'h04, d); chk("R3 pre unchanged", d, 16'h0000);

    // R11 window fixed
    wr(5'h10, 16'h0000, w);
    rd(5'h10, d); chk("R11 window", d, 16'h0FFF);

    // R10 cannot be stopped
    wr(5'h00, 16'h0000, w);
    wr(5'h00, 16'hCCCC, w);
    wr(5'h00, 16'h5555, w);
    wr(5'h08, 16'h0003, w);
    wait_until(w + 3);
    wr(5'h00, 16'hAAAA, r);
    exp_q.push_back(r + 16);
    wait_until(r + 17);

    nvec++;
    if (exp_q.size() != 0) begin
      nfail++;
      $display("FAIL R5: %0d requests missing expected 0", exp_q.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule